// File: doc/BRIEF.md
# Asynchronous Memory Cycle Sequencer

This block runs read and write cycles on an asynchronous, CPU-style memory bus once the bus has been handed to it. A requester presents a start address, a read or write direction, a byte count and the first write byte. The sequencer then generates the bus cycles with clock-counted strobe widths. For each byte it drives a 19-bit address, an 8-bit data path with a separate output enable, and active-low memory-request, read and write strobes.

In a multi-byte run the memory request stays low the whole time. The address steps by one for each byte, and each byte gets its own strobe. On writes, the block pulses `wdata_pop` when it has taken a byte, and the requester then places the next byte on `req_wdata`. On reads, each byte comes back with a one-clock `rd_valid`. A single-clock `done` closes each request. A request made while the bus is not owned produces a one-clock `err` and no activity.

Top module: `memcyc_seq`

## Requirements
- R1: After reset, and whenever no request is in progress, `mreq_n`, `rd_n` and `wr_n` are high, `bus_oe` is low and `busy` is low.
- R2: A write cycle runs in this order. The address is held for one clock with `mreq_n` high. Then `mreq_n` goes low with `bus_oe` high and the byte on `bus_dout` for 2 clocks. Then `wr_n` is low for 2 clocks. Then `wr_n` is high for one clock with the data still driven. Then `mreq_n` goes high.
- R3: A read cycle runs in this order. The address is held for one clock with `mreq_n` high. Then `mreq_n` goes low for one clock with `rd_n` high. Then `rd_n` is low for 3 clocks and `bus_din` is sampled at the last of those clocks. The sampled byte appears on `rd_data` with `rd_valid` high for the one clock in which `rd_n` is back high, and `mreq_n` then goes high.
- R4: A write of N bytes keeps `mreq_n` low from the first byte to the last, with exactly one `mreq_n` fall. The address is start+i (modulo 2^19) for byte i. Each byte has its own 2-clock data setup and 2-clock `wr_n` pulse. `wdata_pop` is high for one clock at the start of each byte's setup, and the next byte must be on `req_wdata` by the following clock edge.
- R5: A read of N bytes keeps `mreq_n` low throughout, with one fall. It gives N `rd_n` pulses at addresses start+i and returns N `rd_valid` bytes in address order.
- R6: `bus_oe` is high only while a write byte is being set up, strobed or held. It is never high while `rd_n` is low, and neither strobe is ever low while `mreq_n` is high.
- R7: `done` is high for exactly one clock, and that clock comes after `mreq_n` has already been high for at least one clock.
- R8: A request with length 0 raises `done` in the clock right after acceptance, with no strobe activity.
- R9: A request made while `bus_owned` is low raises `err` for one clock in the following cycle. It causes no bus activity and no `done`.
- R10: `req_valid` is ignored while `busy` is high.
- R11: A one-byte write takes 3+5N clocks from the accepting edge to the `done` clock, and a read takes 4+4N; with N=1 both take 8.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_owned | input | 1 | High while the bus belongs to this block |
| req_valid | input | 1 | Request strobe, sampled while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 19 | Start address |
| req_len | input | 8 | Byte count (0 = empty request) |
| req_wdata | input | 8 | Current write byte |
| wdata_pop | output | 1 | A write byte was taken; present the next one |
| rd_data | output | 8 | Last byte read |
| rd_valid | output | 1 | `rd_data` holds a new byte |
| done | output | 1 | Request finished (one clock) |
| err | output | 1 | Request refused, bus not owned (one clock) |
| busy | output | 1 | A request is in progress |
| bus_addr | output | 19 | Memory address |
| bus_dout | output | 8 | Data driven toward memory |
| bus_din | input | 8 | Data returned by memory |
| bus_oe | output | 1 | Data driver enable |
| mreq_n | output | 1 | Memory request, active low |
| rd_n | output | 1 | Read strobe, active low |
| wr_n | output | 1 | Write strobe, active low |

## Verification
The assertions check the per-cycle rules on every clock:
- the quiet bus while idle;
- strobe widths and write data setup, measured by run-length counters;
- the data driver being off during reads;
- strobes only inside a memory request;
- the shape of `done` and its position after `mreq_n` returns high;
- a refused request leaving the bus untouched.

Only the scenarios can show the rest. These are the end-to-end latency, the stored and returned bytes at stepped addresses in runs, the single memory-request fall per run, the empty request, and a request ignored mid-run.

// File: rtl/memcyc_seq.sv
module memcyc_seq #(
  parameter int AW = 19,
  parameter int DW = 8,
  parameter int LW = 8,
  parameter int SETUP_CLKS = 2,
  parameter int WR_CLKS = 2,
  parameter int RD_CLKS = 3
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_owned,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [LW-1:0] req_len,
  input  logic [DW-1:0] req_wdata,
  output logic          wdata_pop,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          done,
  output logic          err,
  output logic          busy,
  output logic [AW-1:0] bus_addr,
  output logic [DW-1:0] bus_dout,
  input  logic [DW-1:0] bus_din,
  output logic          bus_oe,
  output logic          mreq_n,
  output logic          rd_n,
  output logic          wr_n
);
  localparam int MAXA = (SETUP_CLKS > WR_CLKS) ? SETUP_CLKS : WR_CLKS;
  localparam int MAXC = (MAXA > RD_CLKS) ? MAXA : RD_CLKS;
  localparam int CW = $clog2(MAXC + 1);

  typedef enum logic [3:0] {
    S_IDLE, S_ADDR, S_SETUP, S_WRLO, S_WRHI,
    S_RSET, S_RDLO, S_RDHI, S_TAIL, S_DONE
  } st_t;

  st_t st;
  logic [CW-1:0] cnt;
  logic [LW-1:0] left;
  logic          is_wr;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q, rdata_q;
  logic          err_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= S_IDLE;
      cnt <= '0;
      left <= '0;
      is_wr <= 1'b0;
      addr_q <= '0;
      wdata_q <= '0;
      rdata_q <= '0;
      err_q <= 1'b0;
    end else begin
      err_q <= 1'b0;
      case (st)
        S_IDLE:
          if (req_valid) begin
            if (!bus_owned) err_q <= 1'b1;
            else if (req_len == '0) st <= S_DONE;
            else begin
              addr_q <= req_addr;
              left <= req_len;
              is_wr <= req_write;
              st <= S_ADDR;
            end
          end
        S_ADDR:
          if (is_wr) begin
            st <= S_SETUP;
            cnt <= CW'(SETUP_CLKS - 1);
            wdata_q <= req_wdata;
          end else st <= S_RSET;
        S_SETUP:
          if (cnt == '0) begin
            st <= S_WRLO;
            cnt <= CW'(WR_CLKS - 1);
          end else cnt <= cnt - CW'(1);
        S_WRLO:
          if (cnt == '0) st <= S_WRHI;
          else cnt <= cnt - CW'(1);
        S_WRHI:
          if (left == LW'(1)) st <= S_TAIL;
          else begin
            left <= left - LW'(1);
            addr_q <= addr_q + AW'(1);
            wdata_q <= req_wdata;
            cnt <= CW'(SETUP_CLKS - 1);
            st <= S_SETUP;
          end
        S_RSET: begin
          st <= S_RDLO;
          cnt <= CW'(RD_CLKS - 1);
        end
        S_RDLO:
          if (cnt == '0) begin
            rdata_q <= bus_din;
            st <= S_RDHI;
          end else cnt <= cnt - CW'(1);
        S_RDHI:
          if (left == LW'(1)) st <= S_TAIL;
          else begin
            left <= left - LW'(1);
            addr_q <= addr_q + AW'(1);
            cnt <= CW'(RD_CLKS - 1);
            st <= S_RDLO;
          end
        S_TAIL: st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  assign mreq_n    = !(st inside {S_SETUP, S_WRLO, S_WRHI, S_RSET, S_RDLO, S_RDHI});
  assign bus_oe    = st inside {S_SETUP, S_WRLO, S_WRHI};
  assign wr_n      = (st != S_WRLO);
  assign rd_n      = (st != S_RDLO);
  assign wdata_pop = (st == S_SETUP) && (cnt == CW'(SETUP_CLKS - 1));
  assign rd_valid  = (st == S_RDHI);
  assign done      = (st == S_DONE);
  assign busy      = (st != S_IDLE);
  assign err       = err_q;
  assign bus_addr  = addr_q;
  assign bus_dout  = wdata_q;
  assign rd_data   = rdata_q;
endmodule

// File: rtl/memcyc_seq_chk.sv
module memcyc_seq_chk #(
  parameter int SETUP_CLKS = 2,
  parameter int WR_CLKS = 2,
  parameter int RD_CLKS = 3
) (
  input logic clk,
  input logic rst_n,
  input logic busy,
  input logic done,
  input logic err,
  input logic bus_oe,
  input logic mreq_n,
  input logic rd_n,
  input logic wr_n
);
  logic [7:0] rd_run, wr_run, su_run;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_run <= '0;
      wr_run <= '0;
      su_run <= '0;
    end else begin
      rd_run <= !rd_n ? rd_run + 8'd1 : 8'd0;
      wr_run <= !wr_n ? wr_run + 8'd1 : 8'd0;
      su_run <= (bus_oe && wr_n) ? su_run + 8'd1 : 8'd0;
    end
  end

  p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (mreq_n && rd_n && wr_n && !bus_oe));
  p_wr_setup_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wr_n) |-> su_run >= 8'(SETUP_CLKS));
  p_wr_width_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wr_n) |-> wr_run == 8'(WR_CLKS));
  p_rd_width_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_n) |-> rd_run == 8'(RD_CLKS));
  p_oe_not_in_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
    bus_oe |-> (!mreq_n && rd_n));
  p_strobe_in_mreq_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!rd_n || !wr_n) |-> (!mreq_n && (rd_n || wr_n)));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_done_after_mreq_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (mreq_n && $past(mreq_n)));
  p_err_quiet_r9: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!busy && mreq_n && !done));
endmodule

bind memcyc_seq memcyc_seq_chk #(
  .SETUP_CLKS(SETUP_CLKS), .WR_CLKS(WR_CLKS), .RD_CLKS(RD_CLKS)
) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .err(err),
  .bus_oe(bus_oe), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n)
);

// File: tb/sim_memcyc_seq.sv
module sim_memcyc_seq;
  localparam int CLK_PER = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bus_owned = 1'b1;
  logic req_valid = 1'b0;
  logic req_write = 1'b0;
  logic [18:0] req_addr = '0;
  logic [7:0] req_len = '0;
  logic [7:0] req_wdata = '0;
  logic wdata_pop, rd_valid, done, err, busy, bus_oe, mreq_n, rd_n, wr_n;
  logic [7:0] rd_data, bus_dout, bus_din;
  logic [18:0] bus_addr;

  logic [7:0] mem [0:1023];
  int total = 0, fails = 0;

  int cyc, mf, wf, rf, badw, badr, bads, bado, dn, rk, widx, wrun, rrun, srun;
  logic done_mreq;
  logic [18:0] fa;
  logic [7:0] wq [0:7];
  logic [7:0] rbuf [0:7];

  always #(CLK_PER/2) clk = ~clk;

  memcyc_seq u0 (
    .clk(clk), .rst_n(rst_n), .bus_owned(bus_owned), .req_valid(req_valid),
    .req_write(req_write), .req_addr(req_addr), .req_len(req_len),
    .req_wdata(req_wdata), .wdata_pop(wdata_pop), .rd_data(rd_data),
    .rd_valid(rd_valid), .done(done), .err(err), .busy(busy),
    .bus_addr(bus_addr), .bus_dout(bus_dout), .bus_din(bus_din),
    .bus_oe(bus_oe), .mreq_n(mreq_n), .rd_n(rd_n), .wr_n(wr_n)
  );

  always @(posedge wr_n) if (mreq_n === 1'b0) mem[bus_addr[9:0]] <= bus_dout;
  assign bus_din = (!mreq_n && !rd_n) ? mem[bus_addr[9:0]] : 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input bit wr, input [18:0] a, input [7:0] len, input bit inject);
    logic pm, pw, pr;
    bit fin;
    mf = 0; wf = 0; rf = 0; badw = 0; badr = 0; bads = 0; bado = 0;
    dn = 0; rk = 0; widx = 0; wrun = 0; rrun = 0; srun = 0; cyc = 0;
    fa = '0; done_mreq = 1'b0; fin = 1'b0;
    pm = mreq_n; pw = wr_n; pr = rd_n;
    req_write = wr; req_addr = a; req_len = len; req_wdata = wq[0];
    req_valid = 1'b1;
    while (!fin && cyc < 200) begin
      @(negedge clk);
      cyc++;
      req_valid = 1'b0;
      if (inject && cyc == 3) begin
        req_valid = 1'b1; req_write = 1'b1; req_addr = 19'h00060; req_len = 8'd1;
      end
      if (pm && !mreq_n) begin mf++; fa = bus_addr; end
      if (pw && !wr_n) begin wf++; if (srun < 2) bads++; srun = 0; end
      if (bus_oe && wr_n) srun++; else if (!bus_oe) srun = 0;
      if (!wr_n) wrun++; else if (!pw) begin if (wrun != 2) badw++; wrun = 0; end
      if (pr && !rd_n) rf++;
      if (!rd_n) rrun++; else if (!pr) begin if (rrun != 3) badr++; rrun = 0; end
      if (bus_oe && !rd_n) bado++;
      if (rd_valid && rk < 8) begin rbuf[rk] = rd_data; rk++; end
      if (wdata_pop) begin widx++; if (widx < 8) req_wdata = wq[widx]; end
      if (done) begin dn++; done_mreq = mreq_n; fin = 1'b1; end
      pm = mreq_n; pw = wr_n; pr = rd_n;
    end
    check(fin, "R7 done seen", int'(fin), 1);
    @(negedge clk);
    check(!done, "R7 done one clock", int'(done), 0);
    check(done_mreq, "R7 mreq high at done", int'(done_mreq), 1);
  endtask

  task automatic t_reset();
    check(mreq_n && rd_n && wr_n, "R1 strobes idle", {mreq_n, rd_n, wr_n}, 3'b111);
    check(!bus_oe, "R1 driver off", int'(bus_oe), 0);
    check(!busy && !done && !err, "R1 status idle", {busy, done, err}, 0);
  endtask

  task automatic t_single_write();
    wq[0] = 8'hA5;
    run(1'b1, 19'h50123, 8'd1, 1'b0);
    check(cyc == 8, "R11 write latency", cyc, 8);
    check(mf == 1 && wf == 1, "R2 one mreq one wr", mf * 16 + wf, 8'h11);
    check(fa == 19'h50123, "R2 address", int'(fa), 32'h50123);
    check(badw == 0 && bads == 0, "R2 setup and width", badw + bads, 0);
    check(mem[10'h123] == 8'hA5, "R2 stored byte", mem[10'h123], 8'hA5);
    check(bado == 0, "R6 driver during read", bado, 0);
  endtask

  task automatic t_single_read();
    run(1'b0, 19'h50123, 8'd1, 1'b0);
    check(cyc == 8, "R11 read latency", cyc, 8);
    check(rf == 1 && badr == 0, "R3 rd pulse", rf * 16 + badr, 8'h10);
    check(rk == 1 && rbuf[0] == 8'hA5, "R3 read data", rbuf[0], 8'hA5);
    check(wf == 0 && bado == 0, "R6 no write during read", wf + bado, 0);
  endtask

  task automatic t_burst_write();
    wq[0] = 8'h11; wq[1] = 8'h22; wq[2] = 8'h33; wq[3] = 8'h44; wq[4] = 8'h55;
    wq[5] = 8'h00;
    run(1'b1, 19'h203FE, 8'd5, 1'b0);
    check(cyc == 28, "R4 burst write latency", cyc, 28);
    check(mf == 1, "R4 single mreq", mf, 1);
    check(wf == 5 && badw == 0 && bads == 0, "R4 wr pulses", wf, 5);
    check(widx == 5, "R4 pops", widx, 5);
    for (int i = 0; i < 5; i++)
      check(mem[10'(10'h3FE + i)] == wq[i], "R4 burst byte", mem[10'(10'h3FE + i)], wq[i]);
  endtask

  task automatic t_burst_read();
    run(1'b0, 19'h203FE, 8'd5, 1'b0);
    check(cyc == 24, "R5 burst read latency", cyc, 24);
    check(mf == 1 && rf == 5 && badr == 0, "R5 strobes", mf * 16 + rf, 8'h15);
    check(rk == 5, "R5 byte count", rk, 5);
    for (int i = 0; i < 5; i++)
      check(rbuf[i] == wq[i], "R5 burst byte", rbuf[i], wq[i]);
  endtask

  task automatic t_zero_len();
    run(1'b1, 19'h00010, 8'd0, 1'b0);
    check(cyc == 1, "R8 immediate done", cyc, 1);
    check(mf == 0 && wf == 0 && rf == 0, "R8 no bus activity", mf + wf + rf, 0);
  endtask

  task automatic t_not_owned();
    int errs = 0, dones = 0, falls = 0;
    logic pm;
    bus_owned = 1'b0;
    pm = mreq_n;
    req_write = 1'b1; req_addr = 19'h00070; req_len = 8'd1; req_valid = 1'b1;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (i == 0) check(err, "R9 err next cycle", int'(err), 1);
      if (err) errs++;
      if (done) dones++;
      if (pm && !mreq_n) falls++;
      pm = mreq_n;
    end
    check(errs == 1, "R9 err one clock", errs, 1);
    check(dones == 0 && falls == 0 && !busy, "R9 no activity", dones + falls, 0);
    bus_owned = 1'b1;
  endtask

  task automatic t_busy_ignore();
    mem[10'h060] = 8'h00;
    wq[0] = 8'h77;
    run(1'b1, 19'h00050, 8'd1, 1'b1);
    check(mf == 1 && wf == 1, "R10 one cycle only", mf * 16 + wf, 8'h11);
    repeat (10) @(negedge clk);
    check(!busy, "R10 no second request", int'(busy), 0);
    check(mem[10'h050] == 8'h77, "R10 first write", mem[10'h050], 8'h77);
    check(mem[10'h060] == 8'h00, "R10 ignored write", mem[10'h060], 8'h00);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_single_write();
    t_single_read();
    t_burst_write();
    t_burst_read();
    t_zero_len();
    t_not_owned();
    t_busy_ignore();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end

  initial begin
    #(CLK_PER * 100000);
    total++;
    fails++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", total, fails);
    $finish;
  end
endmodule